// File: doc/BRIEF.md
# Two-Stage SCL Clock Generator

This block derives the serial-clock timing of a two-wire bus master from the system clock. Two programmable dividers are chained. The first takes a 2-bit divisor A and the second a 6-bit divisor B. Together they produce a prescaled tick once every (A+1)·(B+1) system clocks. A phase counter then spends 11 ticks with SCL driven low and 11 ticks with SCL released. The resulting SCL frequency is the system clock divided by 22·(A+1)·(B+1), so SCL can never run faster than the system clock divided by 22.

Alongside the SCL level, the block emits two single-cycle strobes for the bit engine. The first marks where SDA may change, in the middle of the low phase. The second marks where SDA is sampled, in the middle of the high phase. A follower device may stretch the clock by holding the line low. While SCL is released but the sensed line still reads low, the high-phase count is frozen. The divisor inputs are captured only when an SCL period begins, so software should change them while the bus is idle.

The controlling state machine has three states. PH_OFF: SCL is released and all counters are zero. PH_LOW: SCL is driven low. PH_HIGH: SCL is released and counting continues only while the sensed line is high. The transitions are:
- start: PH_OFF to PH_LOW, once enable is seen high.
- rise: PH_LOW to PH_HIGH, after the 11th low tick.
- fall: PH_HIGH to PH_LOW, after the 11th high tick; this starts a new period.
- stop: any state to PH_OFF, whenever enable is low.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and while `enable` is low, `scl_out` is 1 and both `sda_change` and `sda_sample` are 0.
- R2: When `enable` is sampled high in PH_OFF, `scl_out` is 0 from the very next clock.
- R3: With P = (`div_a`+1)·(`div_b`+1), and with no stretching, `scl_out` stays low for 11·P clocks and high for 11·P clocks, giving a period of 22·P clocks. `div_a` is a 2-bit divisor (1 to 4) and `div_b` is a 6-bit divisor (1 to 64).
- R4: `sda_change` pulses for exactly one clock per period, 6·P clocks after `scl_out` falls, while `scl_out` is 0.
- R5: `sda_sample` pulses for exactly one clock per period, 6·P clocks after `scl_out` rises (plus any stretch), while `scl_out` is 1.
- R6: In the high phase, every clock in which `scl_in` reads 0 freezes the tick count. A stretch of S clocks lengthens the high phase and the period by exactly S clocks.
- R7: Divisor values applied in the middle of a period leave that period's timing unchanged. They take effect from the next fall of `scl_out`.
- R8: Dropping `enable` in the middle of a period releases `scl_out` on the next clock and clears all counters. Re-enabling then starts a complete fresh period.
- R9: With both divisors at 0, the period is 22 clocks. In normal operation the low phase never lasts fewer than 11 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high; forces PH_OFF when low |
| div_a | input | 2 | First-stage divisor (divides by value+1) |
| div_b | input | 6 | Second-stage divisor (divides by value+1) |
| scl_in | input | 1 | Sensed SCL line level, already synchronous to `clk` |
| scl_out | output | 1 | SCL level: 0 = drive low, 1 = release |
| sda_change | output | 1 | One-clock strobe at the SDA change point |
| sda_sample | output | 1 | One-clock strobe at the SDA sample point |

## Verification
On every cycle, the embedded assertions check the following:
- Each strobe lies in its proper SCL phase and lasts a single clock.
- A low `enable` forces the off state with cleared counters.
- A stretch freezes the phase count.
- The captured divisors stay constant within a period.
- The stage counters stay within their limits.
- No low phase that ends in a rise is shorter than 11 clocks.

The exact clock counts cannot be expressed as per-cycle properties. These are the low length, the period, the strobe offsets for several divisor pairs, the lengthening caused by a stretch of known size, and the deferral of a mid-period divisor change. The directed scenarios measure these at the ports.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    assign wrap = step && (cnt_q == limit);

    // R3: a stage count never passes its divisor
    a_r3_stage_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int HALF_TICKS = 11,
    parameter int EDGE_TICK  = 5,
    localparam int CNT_W     = $clog2(HALF_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             scl_in,
    output phase_e           state,
    output logic [CNT_W-1:0] tick_cnt,
    output logic             advance,
    output logic             period_start
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    phase_e           state_d;
    logic [CNT_W-1:0] cnt_d;

    assign advance      = (state == PH_LOW) || ((state == PH_HIGH) && scl_in);
    assign period_start = enable &&
                          ((state == PH_OFF) ||
                           ((state == PH_HIGH) && tick && (tick_cnt == LAST)));

    always_comb begin
        state_d = state;
        cnt_d   = tick_cnt;
        if (!enable) begin
            state_d = PH_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state)
                PH_OFF: begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: if (tick) begin
                    if (tick_cnt == LAST) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = tick_cnt + 1'b1;
                    end
                end
                PH_HIGH: if (tick) begin
                    if (tick_cnt == LAST) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = tick_cnt + 1'b1;
                    end
                end
                default: begin
                    state_d = PH_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_OFF;
            tick_cnt <= '0;
        end else begin
            state    <= state_d;
            tick_cnt <= cnt_d;
        end
    end

    // R6: a stretched high phase freezes the count
    a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == PH_HIGH && !scl_in) |=> ($stable(tick_cnt) && state == PH_HIGH));

    // R8: disable forces the off state with a cleared count
    a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == PH_OFF && tick_cnt == '0));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int A_W        = 2,
    parameter int B_W        = 6,
    parameter int HALF_TICKS = 11,
    parameter int EDGE_TICK  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    input  logic           scl_in,
    output logic           scl_out,
    output logic           sda_change,
    output logic           sda_sample
);
    localparam int CNT_W = $clog2(HALF_TICKS);
    localparam int RUN_W = $clog2(HALF_TICKS + 1);

    phase_e           state;
    logic [CNT_W-1:0] tick_cnt;
    logic             advance, period_start;
    logic             wrap_a, tick;
    logic [A_W-1:0]   lat_a;
    logic [B_W-1:0]   lat_b;
    logic             stage_clear;

    // divisors are captured only when a period begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a <= '0;
            lat_b <= '0;
        end else if (period_start) begin
            lat_a <= div_a;
            lat_b <= div_b;
        end
    end

    assign stage_clear = !enable || (state == PH_OFF);

    scl_div_stage #(.W(A_W)) i_stage_a (
        .clk(clk), .rst_n(rst_n), .clear(stage_clear),
        .step(advance), .limit(lat_a), .wrap(wrap_a)
    );

    scl_div_stage #(.W(B_W)) i_stage_b (
        .clk(clk), .rst_n(rst_n), .clear(stage_clear),
        .step(wrap_a), .limit(lat_b), .wrap(tick)
    );

    scl_phase_fsm #(.HALF_TICKS(HALF_TICKS), .EDGE_TICK(EDGE_TICK)) i_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .scl_in(scl_in), .state(state), .tick_cnt(tick_cnt),
        .advance(advance), .period_start(period_start)
    );

    always_comb scl_out = (state != PH_LOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_change <= 1'b0;
            sda_sample <= 1'b0;
        end else begin
            sda_change <= enable && (state == PH_LOW) && tick &&
                          (tick_cnt == CNT_W'(EDGE_TICK));
            sda_sample <= enable && (state == PH_HIGH) && tick &&
                          (tick_cnt == CNT_W'(EDGE_TICK));
        end
    end

    // checker state: length of the current low run, saturating
    logic [RUN_W-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (scl_out)
            low_run <= '0;
        else if (low_run < RUN_W'(HALF_TICKS))
            low_run <= low_run + 1'b1;
    end

    // R1: disabled means released line and no strobes
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !sda_change && !sda_sample));
    // R4: change strobe sits in the low phase and lasts one clock
    a_r4_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> !scl_out);
    a_r4_change_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |=> !sda_change);
    // R5: sample strobe sits in the high phase and lasts one clock
    a_r5_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> scl_out);
    a_r5_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |=> !sda_sample);
    // R7: captured divisors hold for the whole period
    a_r7_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> ($stable(lat_a) && $stable(lat_b)));
    // R9: a low phase ending in a rise lasts at least HALF_TICKS clocks
    a_r9_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_out) && state == PH_HIGH) |-> (low_run >= RUN_W'(HALF_TICKS)));
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       hold_low = 1'b0;
    logic       scl_in;
    logic       scl_out, sda_change, sda_sample;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    assign scl_in = scl_out & ~hold_low;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a),
        .div_b(div_b), .scl_in(scl_in), .scl_out(scl_out),
        .sda_change(sda_change), .sda_sample(sda_sample)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fall();
        logic p;
        p = scl_out;
        forever begin
            @(negedge clk);
            if (p && !scl_out) break;
            p = scl_out;
        end
    endtask

    // starts at the first low cycle of a period, ends at the first low cycle of the next
    task automatic measure(input int stretch, input bit swap, input logic [1:0] na,
                           input logic [5:0] nb, output int lo, output int per,
                           output int chg, output int smp, output int nchg, output int nsmp);
        int n;
        n = 0; lo = -1; per = -1; chg = -1; smp = -1; nchg = 0; nsmp = 0;
        forever begin
            @(negedge clk);
            n++;
            if (swap && n == 3) begin div_a = na; div_b = nb; end
            if (sda_change) begin nchg++; if (chg < 0) chg = n; end
            if (sda_sample) begin nsmp++; if (smp < 0 && lo >= 0) smp = n - lo; end
            if (lo < 0 && scl_out) begin lo = n; if (stretch > 0) hold_low = 1'b1; end
            if (hold_low && lo >= 0 && n == lo + stretch) hold_low = 1'b0;
            if (lo >= 0 && !scl_out) begin per = n; break; end
            if (n > 30000) break;
        end
    endtask

    task automatic start_cfg(input logic [1:0] a, input logic [5:0] b);
        @(negedge clk);
        enable = 1'b0;
        div_a = a; div_b = b;
        @(negedge clk);
        enable = 1'b1;
        wait_fall();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "scl in reset", scl_out, 1);
        chk("R1", "strobes in reset", sda_change | sda_sample, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!scl_out || sda_change || sda_sample) begin
                chk("R1", "idle after reset", 0, 1);
                break;
            end
        end
        chk("R1", "idle scl", scl_out, 1);
    endtask

    task automatic t_rate(input logic [1:0] a, input logic [5:0] b, input string req);
        int lo, per, chg, smp, nc, ns, p;
        p = (int'(a) + 1) * (int'(b) + 1);
        start_cfg(a, b);
        measure(0, 1'b0, 2'd0, 6'd0, lo, per, chg, smp, nc, ns);
        chk(req, "R3 low length", lo, 11 * p);
        chk(req, "R3 period", per, 22 * p);
        chk(req, "R4 change offset", chg, 6 * p);
        chk(req, "R5 sample offset", smp, 6 * p);
        chk(req, "R4 change count", nc, 1);
        chk(req, "R5 sample count", ns, 1);
    endtask

    task automatic t_stretch();
        int lo, per, chg, smp, nc, ns;
        start_cfg(2'd0, 6'd1);
        measure(7, 1'b0, 2'd0, 6'd0, lo, per, chg, smp, nc, ns);
        chk("R6", "low unaffected", lo, 22);
        chk("R6", "stretched period", per, 44 + 7);
        chk("R6", "stretched sample offset", smp, 12 + 7);
        chk("R6", "sample count", ns, 1);
    endtask

    task automatic t_divchange();
        int lo, per, chg, smp, nc, ns;
        start_cfg(2'd1, 6'd2);
        measure(0, 1'b1, 2'd0, 6'd1, lo, per, chg, smp, nc, ns);
        chk("R7", "old period kept", per, 132);
        chk("R7", "old change offset", chg, 36);
        measure(0, 1'b0, 2'd0, 6'd0, lo, per, chg, smp, nc, ns);
        chk("R7", "new low length", lo, 22);
        chk("R7", "new period", per, 44);
    endtask

    task automatic t_disable();
        int lo, per, chg, smp, nc, ns;
        start_cfg(2'd0, 6'd2);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8", "released after disable", scl_out, 1);
        chk("R8", "no strobes after disable", sda_change | sda_sample, 0);
        repeat (5) @(negedge clk);
        chk("R1", "still released", scl_out, 1);
        enable = 1'b1;
        @(negedge clk);
        chk("R2", "falls one clock after enable", scl_out, 0);
        measure(0, 1'b0, 2'd0, 6'd0, lo, per, chg, smp, nc, ns);
        chk("R8", "fresh low length", lo, 33);
        chk("R8", "fresh change offset", chg, 18);
        chk("R8", "fresh period", per, 66);
    endtask

    initial begin
        t_reset();
        t_rate(2'd0, 6'd0, "R9");
        t_rate(2'd3, 6'd0, "R3");
        t_rate(2'd0, 6'd63, "R3");
        t_rate(2'd3, 6'd63, "R3");
        t_rate(2'd2, 6'd4, "R4");
        t_stretch();
        t_divchange();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule